// File: doc/BRIEF.md
# Two-way cache with per-access write policy

This block is a two-way set-associative cache with 16-byte lines. It sits between a processor port that issues physical word accesses and a memory port that moves one 32-bit word per handshake. Every request carries a two-bit policy code taken from the translation of its page. The code chooses, for that access alone, whether the cache is bypassed, used write-through or used copy-back. Pages with different policies can therefore share the same arrays.

A read miss refills the whole line as four word reads. The refill starts at the word that was asked for and wraps around the line, so the processor receives its data after the first beat. The block only accepts new work once the line is complete. A copy-back store that misses first allocates the line, then re-enters the lookup and merges the store as a hit. Before a refill, a dirty victim is written out word by word. Each set has one recency bit, and that bit chooses the victim.

The controller has six states:
- `S_IDLE` accepts a request.
- `S_LOOKUP` compares the tags.
- `S_EVICT` writes out a dirty victim.
- `S_FILL` refills a line.
- `S_WTHRU` performs the single memory write of a write-through store.
- `S_BYPASS` performs an uncached word access.

The transitions are:
- `S_IDLE` goes to `S_LOOKUP` when a request is accepted.
- `S_LOOKUP` goes to `S_BYPASS` for an uncached code.
- `S_LOOKUP` goes back to `S_IDLE` for a read hit or a copy-back store hit.
- `S_LOOKUP` goes to `S_WTHRU` for any write-through store.
- `S_LOOKUP` goes to `S_EVICT` when the miss victim is dirty, and to `S_FILL` otherwise.
- `S_EVICT` goes to `S_FILL` after the fourth write.
- `S_FILL` goes to `S_IDLE` after a read refill, or back to `S_LOOKUP` after a store refill.
- `S_WTHRU` and `S_BYPASS` return to `S_IDLE` on the memory acknowledge.

Top module: `pcache_top`

## Requirements
- R1: While reset is held and right after it, `req_ready` is 1, `resp_valid` is 0 and `mem_req` is 0.
- R2: Policy code 2'b00 and code 2'b11 are uncached. The access becomes one memory word transfer with the request's byte enables. It allocates nothing, and a later read of a dirty cached copy's address through this code returns the memory's value.
- R3: Policy code 2'b01 selects write-through and 2'b10 selects copy-back. Under either code, a read hit returns the cached word with no memory traffic.
- R4: A cacheable read miss issues four word reads. The first read is at the requested word, and the following reads wrap within the line (word 2 is followed by words 3, 0, 1). `resp_valid` rises after the first read returns, and `req_ready` stays low until the fourth read.
- R5: A write-through store makes exactly one memory write with the request's byte enables. It updates the cache on a hit and allocates nothing on a miss.
- R6: A copy-back store hit updates only the cache, with no memory traffic, and marks the line dirty.
- R7: A copy-back store miss refills the line with four reads and then merges the store. The store itself causes no memory write, and there is exactly one response.
- R8: When the victim is dirty, its four words are written to memory before any refill read is issued.
- R9: Each set keeps one recency bit, and every hit and every fill updates it. A miss evicts the way that was used less recently.
- R10: The byte enables `req_be[i]` gate byte lane i (bits 8i+7..8i) of every store, both in the cache and in memory.
- R11: A request is taken when `req_valid` and `req_ready` are both high. Each request yields one single-cycle `resp_valid` pulse. `mem_req` and `mem_addr` hold steady until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Block is idle and takes a request |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Physical byte address (word aligned) |
| req_be | input | 4 | Byte enables for stores |
| req_wdata | input | 32 | Store data |
| req_pol | input | 2 | Page policy code |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | 32 | Load data, valid with `resp_valid` on loads |
| mem_req | output | 1 | Memory word transfer requested |
| mem_we | output | 1 | Memory transfer is a write |
| mem_addr | output | ADDR_W | Memory word address |
| mem_be | output | 4 | Memory byte enables |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory completes the current word |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |

## Verification
A wrong recency bit or a lost dirty bit does not show on the data port at once. It shows at the memory port on the next miss to the same set: the block refills a line that should have stayed, or it skips or adds a write-back burst. The bench therefore counts the memory reads and writes each request causes, and it records the order of the refill addresses. A store that was merged into the wrong place, or that went to the wrong level, shows up on the next load of that word. The bench detects it by reading the word back through both the cached and the uncached policy codes, which exposes whether the cache and the memory disagree.

// File: rtl/pcache_pkg.sv
package pcache_pkg;
    localparam int WAYS       = 2;
    localparam int LINE_WORDS = 4;
    localparam int WSEL_W     = $clog2(LINE_WORDS);
    localparam int OFF_W      = WSEL_W + 2;

    typedef enum logic [1:0] {
        POL_NC     = 2'b00,
        POL_WT     = 2'b01,
        POL_CB     = 2'b10,
        POL_NC_ALT = 2'b11
    } pol_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOOKUP,
        S_EVICT,
        S_FILL,
        S_WTHRU,
        S_BYPASS
    } state_e;
endpackage

// File: rtl/pcache_tag_store.sv
module pcache_tag_store
    import pcache_pkg::*;
#(
    parameter int SETS  = 16,
    parameter int TAG_W = 24,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [IDX_W-1:0]           rd_set,
    output logic [WAYS-1:0]            rd_valid,
    output logic [WAYS-1:0]            rd_dirty,
    output logic [WAYS-1:0][TAG_W-1:0] rd_tag,
    output logic                       rd_lru,
    input  logic                       wr_en,
    input  logic                       wr_way,
    input  logic [IDX_W-1:0]           wr_set,
    input  logic [TAG_W-1:0]           wr_tag,
    input  logic                       wr_valid,
    input  logic                       wr_dirty,
    input  logic                       lru_we,
    input  logic [IDX_W-1:0]           lru_set,
    input  logic                       lru_val
);
    logic [SETS-1:0] lru_q;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [SETS-1:0]  valid_q;
        logic [SETS-1:0]  dirty_q;
        logic [TAG_W-1:0] tag_q [SETS];
        logic             sel;

        assign sel = wr_en && (wr_way == 1'(w));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                valid_q <= '0;
                dirty_q <= '0;
            end else if (sel) begin
                valid_q[wr_set] <= wr_valid;
                dirty_q[wr_set] <= wr_dirty;
            end
        end

        always_ff @(posedge clk) begin
            if (sel) tag_q[wr_set] <= wr_tag;
        end

        assign rd_valid[w] = valid_q[rd_set];
        assign rd_dirty[w] = dirty_q[rd_set];
        assign rd_tag[w]   = tag_q[rd_set];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      lru_q <= '0;
        else if (lru_we) lru_q[lru_set] <= lru_val;
    end

    assign rd_lru = lru_q[rd_set];
endmodule

// File: rtl/pcache_data_store.sv
module pcache_data_store
    import pcache_pkg::*;
#(
    parameter int SETS = 16,
    localparam int IDX_W = $clog2(SETS),
    localparam int DEPTH = SETS * LINE_WORDS
) (
    input  logic                    clk,
    input  logic [IDX_W-1:0]        rd_set,
    input  logic [WSEL_W-1:0]       rd_word,
    output logic [WAYS-1:0][31:0]   rd_data,
    input  logic                    wr_en,
    input  logic                    wr_way,
    input  logic [IDX_W-1:0]        wr_set,
    input  logic [WSEL_W-1:0]       wr_word,
    input  logic [3:0]              wr_be,
    input  logic [31:0]             wr_data
);
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [31:0] word_q [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && (wr_way == 1'(w))) begin
                for (int b = 0; b < 4; b++) begin
                    if (wr_be[b]) word_q[{wr_set, wr_word}][b*8 +: 8] <= wr_data[b*8 +: 8];
                end
            end
        end

        assign rd_data[w] = word_q[{rd_set, rd_word}];
    end
endmodule

// File: rtl/pcache_top.sv
module pcache_top
    import pcache_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SETS   = 16,
    localparam int IDX_W = $clog2(SETS),
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_be,
    input  logic [31:0]       req_wdata,
    input  logic [1:0]        req_pol,
    output logic              resp_valid,
    output logic [31:0]       resp_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [3:0]        mem_be,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata
);
    state_e state_q, state_d;

    logic [ADDR_W-1:0] r_addr;
    logic              r_we;
    logic [3:0]        r_be;
    logic [31:0]       r_wdata;
    logic [1:0]        r_pol;
    logic              r_way;
    logic [WSEL_W-1:0] cnt_q;

    logic [IDX_W-1:0]  idx;
    logic [TAG_W-1:0]  tag;
    logic [WSEL_W-1:0] wsel;
    logic [WSEL_W-1:0] fill_word;
    logic [WSEL_W-1:0] dsel;
    logic              is_wt, is_cb, cacheable;

    logic [WAYS-1:0]            rd_valid, rd_dirty;
    logic [WAYS-1:0][TAG_W-1:0] rd_tag;
    logic                       rd_lru;
    logic [WAYS-1:0][31:0]      rd_data;
    logic [WAYS-1:0]            hit_vec;
    logic                       hit, hit_way;

    logic              tw_en, tw_way, tw_valid, tw_dirty;
    logic              dw_en, dw_way;
    logic [WSEL_W-1:0] dw_word;
    logic [3:0]        dw_be;
    logic [31:0]       dw_data;
    logic              lru_we, lru_val;

    assign idx       = r_addr[OFF_W +: IDX_W];
    assign tag       = r_addr[ADDR_W-1 -: TAG_W];
    assign wsel      = r_addr[2 +: WSEL_W];
    assign fill_word = wsel + cnt_q;
    assign dsel      = (state_q == S_EVICT) ? cnt_q : wsel;
    assign is_wt     = (r_pol == POL_WT);
    assign is_cb     = (r_pol == POL_CB);
    assign cacheable = is_wt || is_cb;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = rd_valid[w] && (rd_tag[w] == tag);
    end
    assign hit     = |hit_vec;
    assign hit_way = hit_vec[1];

    pcache_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_set   (idx),
        .rd_valid (rd_valid),
        .rd_dirty (rd_dirty),
        .rd_tag   (rd_tag),
        .rd_lru   (rd_lru),
        .wr_en    (tw_en),
        .wr_way   (tw_way),
        .wr_set   (idx),
        .wr_tag   (tag),
        .wr_valid (tw_valid),
        .wr_dirty (tw_dirty),
        .lru_we   (lru_we),
        .lru_set  (idx),
        .lru_val  (lru_val)
    );

    pcache_data_store #(.SETS(SETS)) u_data (
        .clk     (clk),
        .rd_set  (idx),
        .rd_word (dsel),
        .rd_data (rd_data),
        .wr_en   (dw_en),
        .wr_way  (dw_way),
        .wr_set  (idx),
        .wr_word (dw_word),
        .wr_be   (dw_be),
        .wr_data (dw_data)
    );

    assign req_ready = (state_q == S_IDLE);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next state and control outputs
    always_comb begin
        state_d   = state_q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_be    = '0;
        mem_wdata = '0;
        tw_en     = 1'b0;
        tw_way    = r_way;
        tw_valid  = 1'b1;
        tw_dirty  = 1'b0;
        dw_en     = 1'b0;
        dw_way    = r_way;
        dw_word   = wsel;
        dw_be     = r_be;
        dw_data   = r_wdata;
        lru_we    = 1'b0;
        lru_val   = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (req_valid) state_d = S_LOOKUP;
            end
            S_LOOKUP: begin
                if (!cacheable) begin
                    state_d = S_BYPASS;
                end else if (hit) begin
                    lru_we  = 1'b1;
                    lru_val = ~hit_way;
                    state_d = S_IDLE;
                    if (r_we) begin
                        dw_en  = 1'b1;
                        dw_way = hit_way;
                        if (is_cb) begin
                            tw_en    = 1'b1;
                            tw_way   = hit_way;
                            tw_dirty = 1'b1;
                        end else begin
                            state_d = S_WTHRU;
                        end
                    end
                end else if (r_we && is_wt) begin
                    state_d = S_WTHRU;
                end else if (rd_valid[rd_lru] && rd_dirty[rd_lru]) begin
                    state_d = S_EVICT;
                end else begin
                    state_d = S_FILL;
                end
            end
            S_EVICT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_be    = '1;
                mem_addr  = {rd_tag[r_way], idx, cnt_q, 2'b00};
                mem_wdata = rd_data[r_way];
                if (mem_ack && (cnt_q == WSEL_W'(LINE_WORDS - 1))) state_d = S_FILL;
            end
            S_FILL: begin
                mem_req  = 1'b1;
                mem_be   = '1;
                mem_addr = {tag, idx, fill_word, 2'b00};
                if (mem_ack) begin
                    dw_en   = 1'b1;
                    dw_word = fill_word;
                    dw_be   = '1;
                    dw_data = mem_rdata;
                    if (cnt_q == WSEL_W'(LINE_WORDS - 1)) begin
                        tw_en   = 1'b1;
                        lru_we  = 1'b1;
                        lru_val = ~r_way;
                        state_d = r_we ? S_LOOKUP : S_IDLE;
                    end
                end
            end
            S_WTHRU: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_be    = r_be;
                mem_addr  = {r_addr[ADDR_W-1:2], 2'b00};
                mem_wdata = r_wdata;
                if (mem_ack) state_d = S_IDLE;
            end
            S_BYPASS: begin
                mem_req   = 1'b1;
                mem_we    = r_we;
                mem_be    = r_be;
                mem_addr  = {r_addr[ADDR_W-1:2], 2'b00};
                mem_wdata = r_wdata;
                if (mem_ack) state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // Request capture, beat counter and response
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_addr     <= '0;
            r_we       <= 1'b0;
            r_be       <= '0;
            r_wdata    <= '0;
            r_pol      <= '0;
            r_way      <= 1'b0;
            cnt_q      <= '0;
            resp_valid <= 1'b0;
            resp_rdata <= '0;
        end else begin
            resp_valid <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (req_valid) begin
                        r_addr  <= req_addr;
                        r_we    <= req_we;
                        r_be    <= req_be;
                        r_wdata <= req_wdata;
                        r_pol   <= req_pol;
                    end
                end
                S_LOOKUP: begin
                    cnt_q <= '0;
                    if (cacheable && hit && (!r_we || is_cb)) begin
                        resp_valid <= 1'b1;
                        if (!r_we) resp_rdata <= rd_data[hit_way];
                    end
                    if (!hit) r_way <= rd_lru;
                end
                S_EVICT: begin
                    if (mem_ack) cnt_q <= cnt_q + 1'b1;
                end
                S_FILL: begin
                    if (mem_ack) begin
                        cnt_q <= cnt_q + 1'b1;
                        if ((cnt_q == '0) && !r_we) begin
                            resp_valid <= 1'b1;
                            resp_rdata <= mem_rdata;
                        end
                    end
                end
                S_WTHRU: begin
                    if (mem_ack) resp_valid <= 1'b1;
                end
                S_BYPASS: begin
                    if (mem_ack) begin
                        resp_valid <= 1'b1;
                        if (!r_we) resp_rdata <= mem_rdata;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pcache_chk.sv
module pcache_chk
    import pcache_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              resp_valid,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [3:0]        mem_be,
    input state_e            state_q,
    input logic [3:0]        r_be
);
    // R11
    accept_leaves_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    // R11
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

    // R11
    resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    // R8
    fill_reads_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_FILL |-> mem_req && !mem_we);

    // R5
    wthru_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_WTHRU |-> mem_we && (mem_be == r_be));

    // R2
    bypass_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_BYPASS && mem_ack |=> state_q == S_IDLE);
endmodule

bind pcache_top pcache_chk #(.ADDR_W(ADDR_W)) u_pcache_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .resp_valid (resp_valid),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_ack    (mem_ack),
    .mem_addr   (mem_addr),
    .mem_be     (mem_be),
    .state_q    (state_q),
    .r_be       (r_be)
);

// File: tb/test_pcache_top.sv
module test_pcache_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_we = 1'b0;
    logic [31:0] req_addr = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic [1:0]  req_pol = '0;
    logic        resp_valid;
    logic [31:0] resp_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #4 clk = ~clk;

    pcache_top i_pcache_top (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
        .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata), .req_pol(req_pol),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int n_vec = 0;
    int n_bad = 0;
    logic [31:0] phys [256];
    int rd_cnt = 0;
    int wr_cnt = 0;
    int resp_cnt = 0;
    int resp_rdcnt = 0;
    logic [31:0] rd_log [$];
    logic        sb_rd  [$];
    logic [31:0] sb_exp [$];
    string       sb_req [$];

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor (scoreboard pop) followed by the memory model
    always @(negedge clk) begin
        if (rst_n && resp_valid) begin
            resp_rdcnt = rd_cnt;
            resp_cnt++;
            if (sb_rd.size() == 0) begin
                chk(1'b0, "R11 unexpected response", resp_rdata, 32'h0);
            end else begin
                automatic logic        is_rd = sb_rd.pop_front();
                automatic logic [31:0] exp   = sb_exp.pop_front();
                automatic string       req   = sb_req.pop_front();
                chk(!is_rd || (resp_rdata == exp), req, resp_rdata, exp);
            end
        end
        if (mem_req && !mem_ack) begin
            mem_ack = 1'b1;
            if (mem_we) begin
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) phys[mem_addr[9:2]][b*8 +: 8] = mem_wdata[b*8 +: 8];
                wr_cnt++;
            end else begin
                mem_rdata = phys[mem_addr[9:2]];
                rd_log.push_back(mem_addr);
                rd_cnt++;
            end
        end else begin
            mem_ack = 1'b0;
        end
    end

    // Driver: one request, expectation pushed to the scoreboard, traffic checked
    task automatic access(input logic we, input logic [31:0] addr, input logic [3:0] be,
                          input logic [31:0] data, input logic [1:0] pol, input logic [31:0] exp,
                          input string req, input int exp_rd, input int exp_wr,
                          input int resp_after, input logic [31:0] first_addr);
        int rd0, wr0, lg0, rc0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        rd0 = rd_cnt; wr0 = wr_cnt; lg0 = rd_log.size(); rc0 = resp_cnt;
        sb_rd.push_back(!we); sb_exp.push_back(exp); sb_req.push_back(req);
        req_valid = 1'b1; req_we = we; req_addr = addr; req_be = be;
        req_wdata = data; req_pol = pol;
        @(negedge clk);
        req_valid = 1'b0;
        while (resp_cnt == rc0) @(negedge clk);
        if (resp_after >= 0)
            chk(resp_rdcnt - rd0 == resp_after, {req, " early completion"}, 32'(resp_rdcnt - rd0), 32'(resp_after));
        while (!req_ready) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(resp_cnt == rc0 + 1, {req, " single response"}, 32'(resp_cnt - rc0), 32'd1);
        chk(rd_cnt - rd0 == exp_rd, {req, " memory reads"}, 32'(rd_cnt - rd0), 32'(exp_rd));
        chk(wr_cnt - wr0 == exp_wr, {req, " memory writes"}, 32'(wr_cnt - wr0), 32'(exp_wr));
        if (first_addr != 32'hFFFF_FFFF && rd_log.size() > lg0)
            chk(rd_log[lg0] == first_addr, {req, " first refill address"}, rd_log[lg0], first_addr);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL R11 watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
        finish_run();
    end

    localparam logic [1:0] NC = 2'b00, WT = 2'b01, CB = 2'b10, NC3 = 2'b11;
    localparam logic [31:0] NOA = 32'hFFFF_FFFF;

    initial begin
        int lg;
        for (int i = 0; i < 256; i++) phys[i] = 32'hA000_0000 | 32'(i * 4);
        repeat (3) @(negedge clk);
        // R1: state during reset
        chk(req_ready == 1'b1, "R1 ready in reset", 32'(req_ready), 32'h1);
        chk(resp_valid == 1'b0, "R1 resp in reset", 32'(resp_valid), 32'h0);
        chk(mem_req == 1'b0, "R1 mem_req in reset", 32'(mem_req), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !resp_valid && !mem_req, "R1 after reset",
            {29'h0, req_ready, resp_valid, mem_req}, 32'h4);

        // R4: read miss, critical word first, wrap order, early completion
        lg = rd_log.size();
        access(0, 32'h018, 4'hF, 0, CB, 32'hA000_0018, "R4 read miss", 4, 0, 1, 32'h018);
        chk(rd_log[lg+2] == 32'h010, "R4 wrap order", rd_log[lg+2], 32'h010);
        // R3: read hit, no traffic
        access(0, 32'h01C, 4'hF, 0, CB, 32'hA000_001C, "R3 read hit", 0, 0, -1, NOA);
        // R6: copy-back store hit stays in cache
        access(1, 32'h014, 4'hF, 32'h1111_1111, CB, 0, "R6 store hit", 0, 0, -1, NOA);
        // R2: uncached read sees memory, not the dirty copy
        access(0, 32'h014, 4'hF, 0, NC, 32'hA000_0014, "R2 bypass stale", 1, 0, -1, NOA);
        access(0, 32'h014, 4'hF, 0, CB, 32'h1111_1111, "R6 dirty data", 0, 0, -1, NOA);
        // R5: write-through miss, no allocation
        access(1, 32'h118, 4'hF, 32'h2222_2222, WT, 0, "R5 wt miss", 0, 1, -1, NOA);
        access(0, 32'h118, 4'hF, 0, WT, 32'h2222_2222, "R5 no allocate", 4, 0, 1, 32'h118);
        // R10 + R5: write-through hit with one byte lane
        access(1, 32'h110, 4'b0010, 32'h0000_3300, WT, 0, "R10 wt byte store", 0, 1, -1, NOA);
        access(0, 32'h110, 4'hF, 0, WT, 32'hA000_3310, "R10 cached byte merge", 0, 0, -1, NOA);
        access(0, 32'h110, 4'hF, 0, NC, 32'hA000_3310, "R5 memory updated", 1, 0, -1, NOA);
        // R8 + R9: set 1 way 0 is dirty and least recent
        access(0, 32'h210, 4'hF, 0, CB, 32'hA000_0210, "R8 dirty eviction", 4, 4, 1, 32'h210);
        access(0, 32'h014, 4'hF, 0, NC, 32'h1111_1111, "R8 written back", 1, 0, -1, NOA);
        // R9: recency decides the victim
        access(0, 32'h110, 4'hF, 0, WT, 32'hA000_3310, "R9 touch way1", 0, 0, -1, NOA);
        access(0, 32'h310, 4'hF, 0, CB, 32'hA000_0310, "R9 evict way0", 4, 0, 1, 32'h310);
        access(0, 32'h110, 4'hF, 0, WT, 32'hA000_3310, "R9 kept line", 0, 0, -1, NOA);
        access(0, 32'h214, 4'hF, 0, CB, 32'hA000_0214, "R9 evicted line", 4, 0, 1, 32'h214);
        // R7: copy-back store miss allocates
        access(1, 32'h020, 4'hF, 32'h0000_0055, CB, 0, "R7 store miss", 4, 0, -1, 32'h020);
        access(0, 32'h020, 4'hF, 0, NC, 32'hA000_0020, "R7 memory untouched", 1, 0, -1, NOA);
        access(0, 32'h020, 4'hF, 0, CB, 32'h0000_0055, "R7 merged store", 0, 0, -1, NOA);
        access(0, 32'h024, 4'hF, 0, CB, 32'hA000_0024, "R7 rest of line", 0, 0, -1, NOA);
        // R2: code 2'b11 is uncached
        access(0, 32'h024, 4'hF, 0, NC3, 32'hA000_0024, "R2 code 11 bypass", 1, 0, -1, NOA);
        // R10: copy-back byte store
        access(1, 32'h024, 4'b0001, 32'h0000_00EE, CB, 0, "R10 cb byte store", 0, 0, -1, NOA);
        access(0, 32'h024, 4'hF, 0, CB, 32'hA000_00EE, "R10 cb byte merge", 0, 0, -1, NOA);
        // R2: uncached store with byte enables, then cached view
        access(1, 32'h030, 4'b1100, 32'h7766_0000, NC, 0, "R2 bypass store", 0, 1, -1, NOA);
        lg = rd_log.size();
        access(0, 32'h03C, 4'hF, 0, WT, 32'hA000_003C, "R4 last word miss", 4, 0, 1, 32'h03C);
        chk(rd_log[lg+1] == 32'h030, "R4 wrap from word 3", rd_log[lg+1], 32'h030);
        access(0, 32'h030, 4'hF, 0, WT, 32'h7766_0030, "R2 bypass store seen", 0, 0, -1, NOA);

        finish_run();
    end
endmodule